// File: doc/BRIEF.md
# Bus Tenure Throttle

The block sits between a DMA data mover and the requester of a shared bus. While the DMA has work pending it raises a bus request. It counts the bytes the mover transfers during that ownership. Once the count meets a programmed byte budget, it drops the request and pulses a release strobe so the mover stops issuing beats. It then holds the request low for a programmed number of microsecond ticks before it may ask for the bus again. Arbitration and the data path stay outside the block.

Both the byte budget and the idle gap are chosen by small power-of-two code fields. A zero code means no budget (the DMA keeps the bus for as long as it is pending) or no idle gap (the request returns on the cycle after the release). A beat is never split: the beat that reaches or crosses the budget completes, and the release follows it. A fall of the pending input cancels everything. The outputs go low, the byte count and the gap timer are cleared, and the next ownership starts with a full budget.

Top module: `bus_tenure_throttle`

## Requirements
- R1: While rst is high, and on the first cycle after it, bus_req and tenure_release are 0.
- R2: When dma_pending is high and no gap is running, bus_req is 1 on the cycle after the clock edge that samples dma_pending high.
- R3: For tenure_code c in 1..7 the budget is 2^(7+c) bytes (256 for c=1 up to 16384 for c=7). Each beat_valid beat adds beat_bytes to the ownership's byte count. The beat that makes the count greater than or equal to the budget is the last beat, so one ownership carries ceil(budget / beat_bytes) beats of constant size.
- R4: tenure_code 0 sets no budget: tenure_release never rises and bus_req stays high while dma_pending is high, however many bytes move.
- R5: tenure_release is high for exactly one cycle. That cycle directly follows the edge that sampled the last beat, and bus_req is 0 during it.
- R6: With gap_code 0, bus_req is high again on the cycle after the tenure_release pulse.
- R7: For gap_code g in 1..7 the gap is 2^(3+g) microsecond ticks (16 up to 1024). The value of gap_code at the release edge is used. Only us_tick pulses sampled after the release edge count. bus_req stays 0 until the edge after the one that samples the last tick, and is 1 from then on.
- R8: gap_code values 8 to 15 give the same 1024-tick gap as code 7.
- R9: When dma_pending is sampled low, bus_req and tenure_release are 0 on the next cycle and the byte count and the gap are discarded. The next request therefore comes one cycle after dma_pending returns, with no pending gap and a full byte budget.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_pending | input | 1 | DMA has work waiting to move |
| tenure_code | input | 3 | Byte budget code per ownership, 0 = no budget |
| gap_code | input | 4 | Idle gap code between ownerships, 0 = no gap, 8..15 same as 7 |
| beat_valid | input | 1 | The mover transfers one beat this cycle |
| beat_bytes | input | 4 | Byte size of the current beat |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| bus_req | output | 1 | Registered bus request |
| tenure_release | output | 1 | Registered one-cycle strobe telling the mover to stop |

## Verification
Every result is one register away from its cause. bus_req rises on the edge after dma_pending or after the edge that clears the gap. tenure_release and the fall of bus_req both come from the edge that samples the last beat. The gap's end takes one further edge after the edge that counts the last tick. The bench drives inputs and reads outputs only on falling edges, so each check falls on the half-cycle right after the edge that should have changed the output. It sweeps every tenure code with several beat sizes, and every gap code with back-to-back ticks, comparing beat and tick counts with budgets computed arithmetically.

// File: rtl/bt_throttle_pkg.sv
package bt_throttle_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OWN  = 2'd1,
    ST_GAP  = 2'd2
  } bt_state_e;

endpackage

// File: rtl/bt_code_decode.sv
module bt_code_decode #(
  parameter int TEN_CODE_W    = 3,
  parameter int GAP_CODE_W    = 4,
  parameter int TEN_BASE_LOG2 = 8,
  parameter int GAP_BASE_LOG2 = 4,
  parameter int MAX_CODE      = 7,
  parameter int CNT_W         = 16,
  parameter int GAP_W         = 11
) (
  input  logic [TEN_CODE_W-1:0] tenure_code,
  input  logic [GAP_CODE_W-1:0] gap_code,
  output logic [CNT_W-1:0]      byte_limit,
  output logic [GAP_W-1:0]      gap_ticks
);

  localparam int TEN_ENTRIES = 1 << TEN_CODE_W;
  localparam int GAP_ENTRIES = 1 << GAP_CODE_W;

  logic [CNT_W-1:0] lim_tab [TEN_ENTRIES];
  logic [GAP_W-1:0] gap_tab [GAP_ENTRIES];

  // Byte budget per code: zero means no budget, higher codes clamp at MAX_CODE.
  for (genvar i = 0; i < TEN_ENTRIES; i++) begin : g_lim
    localparam int EFF = (i > MAX_CODE) ? MAX_CODE : i;
    if (EFF == 0) begin : g_none
      assign lim_tab[i] = '0;
    end else begin : g_pow
      assign lim_tab[i] = CNT_W'(1) << (TEN_BASE_LOG2 + EFF - 1);
    end
  end

  // Gap length per code in ticks: zero means no wait, codes past MAX_CODE clamp.
  for (genvar j = 0; j < GAP_ENTRIES; j++) begin : g_gap
    localparam int EFF = (j > MAX_CODE) ? MAX_CODE : j;
    if (EFF == 0) begin : g_none
      assign gap_tab[j] = '0;
    end else begin : g_pow
      assign gap_tab[j] = GAP_W'(1) << (GAP_BASE_LOG2 + EFF - 1);
    end
  end

  assign byte_limit = lim_tab[tenure_code];
  assign gap_ticks  = gap_tab[gap_code];

endmodule

// File: rtl/bt_byte_meter.sv
module bt_byte_meter #(
  parameter int CNT_W  = 16,
  parameter int BEAT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              add,
  input  logic [BEAT_W-1:0] beat_bytes,
  input  logic [CNT_W-1:0]  byte_limit,
  output logic              limit_hit
);

  localparam int SUM_W = CNT_W + 1;

  logic [CNT_W-1:0] byte_cnt;
  logic [SUM_W-1:0] next_sum;
  logic             limited;

  assign limited   = (byte_limit != '0);
  assign next_sum  = {1'b0, byte_cnt} + {{(SUM_W-BEAT_W){1'b0}}, beat_bytes};
  // The beat that meets or crosses the budget is the last one of the tenure.
  assign limit_hit = limited && (next_sum >= {1'b0, byte_limit});

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      byte_cnt <= '0;
    end else if (add && limited) begin
      byte_cnt <= next_sum[CNT_W-1:0];
    end
  end

  // R3: accumulation never wraps while a budget applies
  assert_meter_no_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (add && !clear && limited) |=> (byte_cnt >= $past(byte_cnt)));

endmodule

// File: rtl/bt_gap_timer.sv
module bt_gap_timer #(
  parameter int GAP_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             load,
  input  logic [GAP_W-1:0] load_val,
  input  logic             tick,
  output logic             gap_zero
);

  logic [GAP_W-1:0] gap_cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      gap_cnt <= '0;
    end else if (load) begin
      gap_cnt <= load_val;
    end else if (tick && (gap_cnt != '0)) begin
      gap_cnt <= gap_cnt - 1'b1;
    end
  end

  assign gap_zero = (gap_cnt == '0);

  // R7: an expired gap stays expired until the next load
  assert_gap_no_underflow_R7: assert property (@(posedge clk) disable iff (rst)
    (gap_zero && !load) |=> gap_zero);

endmodule

// File: rtl/bus_tenure_throttle.sv
module bus_tenure_throttle
  import bt_throttle_pkg::*;
#(
  parameter int TEN_CODE_W    = 3,
  parameter int GAP_CODE_W    = 4,
  parameter int BEAT_W        = 4,
  parameter int TEN_BASE_LOG2 = 8,
  parameter int GAP_BASE_LOG2 = 4,
  parameter int MAX_CODE      = 7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  dma_pending,
  input  logic [TEN_CODE_W-1:0] tenure_code,
  input  logic [GAP_CODE_W-1:0] gap_code,
  input  logic                  beat_valid,
  input  logic [BEAT_W-1:0]     beat_bytes,
  input  logic                  us_tick,
  output logic                  bus_req,
  output logic                  tenure_release
);

  localparam int CNT_W = TEN_BASE_LOG2 + MAX_CODE + 1;
  localparam int GAP_W = GAP_BASE_LOG2 + MAX_CODE;

  bt_state_e        state;
  logic [CNT_W-1:0] byte_limit;
  logic [GAP_W-1:0] gap_ticks;
  logic             limit_hit;
  logic             gap_zero;
  logic             owning;
  logic             last_beat;
  logic             flush;

  assign owning    = (state == ST_OWN);
  assign last_beat = owning && beat_valid && limit_hit;
  assign flush     = !dma_pending;

  bt_code_decode #(
    .TEN_CODE_W   (TEN_CODE_W),
    .GAP_CODE_W   (GAP_CODE_W),
    .TEN_BASE_LOG2(TEN_BASE_LOG2),
    .GAP_BASE_LOG2(GAP_BASE_LOG2),
    .MAX_CODE     (MAX_CODE),
    .CNT_W        (CNT_W),
    .GAP_W        (GAP_W)
  ) u_decode (
    .tenure_code(tenure_code),
    .gap_code   (gap_code),
    .byte_limit (byte_limit),
    .gap_ticks  (gap_ticks)
  );

  bt_byte_meter #(
    .CNT_W (CNT_W),
    .BEAT_W(BEAT_W)
  ) u_meter (
    .clk       (clk),
    .rst       (rst),
    .clear     (!owning || flush),
    .add       (owning && beat_valid),
    .beat_bytes(beat_bytes),
    .byte_limit(byte_limit),
    .limit_hit (limit_hit)
  );

  bt_gap_timer #(
    .GAP_W(GAP_W)
  ) u_gap (
    .clk     (clk),
    .rst     (rst),
    .clear   (flush),
    .load    (last_beat),
    .load_val(gap_ticks),
    .tick    (us_tick && (state == ST_GAP)),
    .gap_zero(gap_zero)
  );

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      state          <= ST_IDLE;
      bus_req        <= 1'b0;
      tenure_release <= 1'b0;
    end else begin
      tenure_release <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          state   <= ST_OWN;
          bus_req <= 1'b1;
        end
        ST_OWN: begin
          if (last_beat) begin
            state          <= ST_GAP;
            bus_req        <= 1'b0;
            tenure_release <= 1'b1;
          end
        end
        ST_GAP: begin
          if (gap_zero) begin
            state   <= ST_OWN;
            bus_req <= 1'b1;
          end
        end
        default: begin
          state   <= ST_IDLE;
          bus_req <= 1'b0;
        end
      endcase
    end
  end

  assert_release_single_R5: assert property (@(posedge clk) disable iff (rst)
    tenure_release |=> !tenure_release);

  assert_release_drops_req_R5: assert property (@(posedge clk) disable iff (rst)
    tenure_release |-> !bus_req);

  assert_release_follows_beat_R3: assert property (@(posedge clk) disable iff (rst)
    tenure_release |-> $past(beat_valid));

  assert_no_budget_no_release_R4: assert property (@(posedge clk) disable iff (rst)
    (tenure_code == '0) |=> !tenure_release);

  assert_gap_blocks_req_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_GAP && !gap_zero && dma_pending) |=> !bus_req);

  assert_flush_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !dma_pending |=> (!bus_req && !tenure_release));

endmodule

// File: tb/tb_bus_tenure_throttle.sv
module tb_bus_tenure_throttle;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dma_pending = 1'b0;
  logic [2:0] tenure_code = '0;
  logic [3:0] gap_code = '0;
  logic       beat_valid = 1'b0;
  logic [3:0] beat_bytes = 4'd8;
  logic       us_tick = 1'b0;
  logic       bus_req;
  logic       tenure_release;

  int vectors = 0;
  int fails   = 0;

  always #4 clk = ~clk;

  bus_tenure_throttle dut (
    .clk           (clk),
    .rst           (rst),
    .dma_pending   (dma_pending),
    .tenure_code   (tenure_code),
    .gap_code      (gap_code),
    .beat_valid    (beat_valid),
    .beat_bytes    (beat_bytes),
    .us_tick       (us_tick),
    .bus_req       (bus_req),
    .tenure_release(tenure_release)
  );

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int budget(input int c);
    return (c == 0) ? 0 : (1 << (7 + c));
  endfunction

  function automatic int gap_len(input int g);
    int e;
    e = (g > 7) ? 7 : g;
    return (e == 0) ? 0 : (1 << (3 + e));
  endfunction

  // Entered on a falling edge where bus_req should be high; leaves on the
  // falling edge where the release is seen or the beat cap is reached.
  task automatic do_beats(input int cap, output int beats, output bit rel);
    beats = 0;
    rel   = 1'b0;
    for (int i = 0; i < 40000; i++) begin
      if (tenure_release) begin
        rel = 1'b1;
        break;
      end
      if (beats == cap) break;
      beat_valid = bus_req;
      if (bus_req) beats++;
      @(negedge clk);
    end
    beat_valid = 1'b0;
  endtask

  // Called on the release falling edge; applies the gap's ticks back to back.
  task automatic run_gap(input int g, input string tag);
    int n;
    bit early;
    n = gap_len(g);
    early = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (bus_req) early = 1'b1;
    end
    for (int t = 0; t < n; t++) begin
      us_tick = 1'b1;
      @(negedge clk);
      us_tick = 1'b0;
      if (bus_req) early = 1'b1;
    end
    check({tag, " bus_req held low through gap"}, early, 0);
    @(negedge clk);
    check({tag, " bus_req back after last tick"}, bus_req, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    vectors++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int  beats;
    bit  rel;
    int  sizes [3];
    sizes = '{3, 8, 7};

    // R1: reset holds everything low, even with pending high
    dma_pending = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 bus_req in reset", bus_req, 0);
    check("R1 release in reset", tenure_release, 0);
    dma_pending = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check("R1 bus_req after reset", bus_req, 0);
    repeat (3) @(negedge clk);
    check("R2 no request without pending", bus_req, 0);

    // R2: request one edge after pending is sampled
    dma_pending = 1'b1;
    tenure_code = 3'd1;
    beat_bytes  = 4'd1;
    @(negedge clk);
    check("R2 request after pending", bus_req, 1);

    // R3/R5/R6: sweep every budget code with several beat sizes, gap 0
    do_beats(100000, beats, rel);
    check("R3 code1 size1 released", rel, 1);
    check("R3 code1 size1 beats", beats, budget(1));
    for (int c = 1; c <= 7; c++) begin
      for (int s = 0; s < 3; s++) begin
        if (s == 2 && c > 2) continue;
        // on the release falling edge: reconfigure for the next ownership
        check("R5 bus_req low with release", bus_req, 0);
        tenure_code = 3'(c);
        beat_bytes  = 4'(sizes[s]);
        @(negedge clk);
        check("R5 release is one cycle", tenure_release, 0);
        check("R6 request returns with gap 0", bus_req, 1);
        do_beats(100000, beats, rel);
        check($sformatf("R3 code%0d size%0d released", c, sizes[s]), rel, 1);
        check($sformatf("R3 code%0d size%0d beats", c, sizes[s]), beats,
              (budget(c) + sizes[s] - 1) / sizes[s]);
      end
    end

    // R4: code 0 never releases
    tenure_code = 3'd0;
    beat_bytes  = 4'd8;
    @(negedge clk);
    check("R6 request after last budget sweep", bus_req, 1);
    do_beats(3000, beats, rel);
    check("R4 no release without budget", rel, 0);
    check("R4 beats moved", beats, 3000);
    check("R4 bus_req still high", bus_req, 1);

    // R7/R8: every gap code, budget 256 with 8-byte beats
    tenure_code = 3'd1;
    for (int g = 1; g <= 15; g++) begin
      gap_code = 4'(g);
      do_beats(100000, beats, rel);
      check($sformatf("R3 tenure before gap%0d", g), beats, 32);
      if (g <= 7) run_gap(g, $sformatf("R7 gap%0d", g));
      else        run_gap(g, $sformatf("R8 gap%0d", g));
    end

    // R9: pending drop during ownership clears the byte count
    gap_code = 4'd2;
    do_beats(10, beats, rel);
    check("R9 partial ownership no release", rel, 0);
    dma_pending = 1'b0;
    @(negedge clk);
    check("R9 bus_req low after pending drop", bus_req, 0);
    check("R9 release low after pending drop", tenure_release, 0);
    dma_pending = 1'b1;
    @(negedge clk);
    check("R2 request after pending returns", bus_req, 1);
    do_beats(100000, beats, rel);
    check("R9 fresh budget after drop", beats, 32);
    // R9: pending drop during a gap discards the gap
    dma_pending = 1'b0;
    @(negedge clk);
    check("R9 quiet during drop in gap", bus_req, 0);
    dma_pending = 1'b1;
    @(negedge clk);
    check("R9 gap discarded", bus_req, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule